// File: doc/BRIEF.md
# Fault-Counting Hiccup Controller

This block sits behind the cycle-by-cycle current-limit stage of a switching regulator. Every time the limit comparator cuts a drive pulse short, one of two phase inputs pulses high for a clock. The block adds these events into a saturating fault accumulator. When the accumulator's top bit becomes set, the block raises a soft-start discharge request. That request holds the converter off, so the stage moves from pulse-by-pulse limiting into hiccup mode.

A free-running clear timer empties the accumulator at a fixed interval, so that the converter can try a new soft-start. The timer period must be longer than the time the accumulator needs to fill under a sustained overload. A second counter records hiccup episodes. When these reach a set limit, the block latches a shutdown state that only a manual clear or a reset ends. The terminate events and the clear are plain single-cycle control pulses, not a data stream, so there is no handshake and no back-pressure. The analog soft-start ramp lies outside the block.

Top module: `hiccup_fault_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `ss_discharge` and `shutdown` are 0, and the accumulator, the episode count and the timer are all zero.
- R2: At each clock edge, the accumulator increases by the number of asserted inputs among `term_a` and `term_b`. One asserted input adds 1 and both add 2.
- R3: `ss_discharge` is 1 whenever the accumulator is at least 2^(CNT_W-1), which means its top bit is set. It shows after the edge that brings the count to that value.
- R4: The accumulator saturates at 2^CNT_W-1 and never wraps, so further events keep `ss_discharge` high.
- R5: The clear timer produces a clear at the CLR_PERIOD-th edge after reset or after a manual clear, and then at every CLR_PERIOD edges. That edge sets the accumulator to zero and drops the events of that same cycle.
- R6: The episode count increases by exactly one, at the edge after each 0-to-1 change of the accumulator's top bit. It saturates at HIC_LIMIT.
- R7: `shutdown` becomes 1 when the episode count reaches HIC_LIMIT. It stays 1 until a reset or a manual clear. While it is 1, `ss_discharge` is held at 1, whatever the timer clears.
- R8: At the edge where `man_clr` is 1, the accumulator, the episode count, the shutdown state and the timer all go to zero. This takes priority over events in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| term_a | input | 1 | Pulse-terminate event from phase A, one clock per event |
| term_b | input | 1 | Pulse-terminate event from phase B, one clock per event |
| man_clr | input | 1 | Synchronous manual clear of all counting state |
| ss_discharge | output | 1 | Soft-start discharge request (hiccup or shutdown) |
| shutdown | output | 1 | Latched shutdown after too many hiccup episodes |

## Verification
Two things can land on the same edge: a terminate event and the timer's periodic clear. The bench tracks the timer phase in its own model. It fires events from both phases exactly on the clearing edge. It then shows that those events were lost: 15 further events must still leave `ss_discharge` low, and the 16th must raise it. In the same way, a manual clear is issued together with events from both phases. This shows that the clear wins and that the timer restarts from zero.

// File: rtl/hic_pkg.sv
package hic_pkg;
  typedef logic [1:0] evt_inc_t;

  // number of phases reporting a terminated pulse this cycle
  function automatic evt_inc_t phase_events(input logic a, input logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction
endpackage

// File: rtl/hic_fault_accum.sv
module hic_fault_accum
  import hic_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic     clk,
  input  logic     rst_n,
  input  evt_inc_t inc,
  input  logic     clr_tick,
  input  logic     man_clr,
  output logic     trig
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, inc};

  always_comb begin
    if (man_clr || clr_tick)  cnt_d = '0;
    else if (sum[CNT_W])      cnt_d = CNT_MAX;
    else                      cnt_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign trig = cnt_q[CNT_W-1];

  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_tick && !man_clr) |=> cnt_q == CNT_MAX);
  a_r2_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_tick && !man_clr) |=> cnt_q >= $past(cnt_q));
  a_r5_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_tick |=> cnt_q == '0);
  a_r8_mclr_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    man_clr |=> cnt_q == '0);
endmodule

// File: rtl/hic_clear_timer.sv
module hic_clear_timer #(
  parameter int PERIOD = 12_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic man_clr,
  output logic tick
);
  localparam int TW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

  logic [TW-1:0] tmr_q;

  assign tick = (tmr_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tmr_q <= '0;
    else if (man_clr || tick)  tmr_q <= '0;
    else                       tmr_q <= tmr_q + 1'b1;
  end

  a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q <= LAST);
  a_r5_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/hic_episode_ctr.sv
module hic_episode_ctr #(
  parameter int HIC_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic man_clr,
  output logic shutdown
);
  localparam int HW = $clog2(HIC_LIMIT + 1);
  localparam logic [HW-1:0] LIM = HW'(HIC_LIMIT);

  logic          trig_q;
  logic          rise;
  logic [HW-1:0] ep_q;

  assign rise = trig && !trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      ep_q   <= '0;
    end else if (man_clr) begin
      trig_q <= 1'b0;
      ep_q   <= '0;
    end else begin
      trig_q <= trig;
      if (rise && ep_q != LIM) ep_q <= ep_q + 1'b1;
    end
  end

  assign shutdown = (ep_q == LIM);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !man_clr) |=> shutdown);
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !man_clr) |=> $stable(ep_q));
  a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ep_q <= LIM);
endmodule

// File: rtl/hiccup_fault_ctrl.sv
module hiccup_fault_ctrl
  import hic_pkg::*;
#(
  parameter int CNT_W      = 14,
  parameter int CLR_PERIOD = 12_000_000,
  parameter int HIC_LIMIT  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic term_a,
  input  logic term_b,
  input  logic man_clr,
  output logic ss_discharge,
  output logic shutdown
);
  evt_inc_t inc;
  logic     clr_tick;
  logic     trig;

  assign inc = phase_events(term_a, term_b);

  hic_clear_timer #(.PERIOD(CLR_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .man_clr(man_clr), .tick(clr_tick)
  );

  hic_fault_accum #(.CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .inc(inc), .clr_tick(clr_tick),
    .man_clr(man_clr), .trig(trig)
  );

  hic_episode_ctr #(.HIC_LIMIT(HIC_LIMIT)) u_episode (
    .clk(clk), .rst_n(rst_n), .trig(trig), .man_clr(man_clr),
    .shutdown(shutdown)
  );

  assign ss_discharge = trig || shutdown;

  a_r8_mclr_out: assert property (@(posedge clk) disable iff (!rst_n)
    man_clr |=> (!shutdown && !ss_discharge));
  a_r7_discharge: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> ss_discharge);
endmodule

// File: tb/tb_hiccup_fault_ctrl.sv
module tb_hiccup_fault_ctrl;
  localparam int CNT_W = 5;
  localparam int PER   = 64;
  localparam int LIM   = 3;
  localparam int TOPV  = 16;
  localparam int MAXC  = 31;

  logic clk = 0;
  logic rst_n = 0;
  logic term_a = 0, term_b = 0, man_clr = 0;
  logic ss_discharge, shutdown;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  int m_cnt = 0, m_tmr = 0, m_hic = 0;
  bit m_trig_q = 0;

  bit    q_ssd[$];
  bit    q_sd[$];
  string q_tag[$];

  always #2 clk = ~clk;

  hiccup_fault_ctrl #(.CNT_W(CNT_W), .CLR_PERIOD(PER), .HIC_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .term_a(term_a), .term_b(term_b),
    .man_clr(man_clr), .ss_discharge(ss_discharge), .shutdown(shutdown)
  );

  // starts and ends at a falling edge
  task automatic step(input bit a, input bit b, input bit mc, input string tag);
    bit clr, top_old, rise;
    bit e_sd;
    term_a = a; term_b = b; man_clr = mc;
    if (mc) begin
      m_cnt = 0; m_tmr = 0; m_hic = 0; m_trig_q = 0;
    end else begin
      clr = (m_tmr == PER - 1);
      m_tmr = clr ? 0 : m_tmr + 1;
      top_old = (m_cnt >= TOPV);
      rise = top_old && !m_trig_q;
      m_trig_q = top_old;
      if (rise && m_hic < LIM) m_hic = m_hic + 1;
      if (clr) m_cnt = 0;
      else begin
        m_cnt = m_cnt + int'(a) + int'(b);
        if (m_cnt > MAXC) m_cnt = MAXC;
      end
    end
    @(posedge clk);
    e_sd = (m_hic == LIM);
    q_ssd.push_back((m_cnt >= TOPV) || e_sd);
    q_sd.push_back(e_sd);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compares results as they appear
  initial begin
    forever begin
      @(negedge clk);
      if (q_tag.size() > 0) begin
        bit es, ed;
        string t;
        es = q_ssd.pop_front(); ed = q_sd.pop_front(); t = q_tag.pop_front();
        checks++;
        if (ss_discharge !== es || shutdown !== ed) begin
          errors++;
          $display("FAIL %s: ss_discharge=%b shutdown=%b expected %b %b",
                   t, ss_discharge, shutdown, es, ed);
        end
      end
    end
  end

  task automatic direct(input bit exp_ssd, input bit exp_sd, input string tag);
    checks++;
    if (ss_discharge !== exp_ssd || shutdown !== exp_sd) begin
      errors++;
      $display("FAIL %s: ss_discharge=%b shutdown=%b expected %b %b",
               tag, ss_discharge, shutdown, exp_ssd, exp_sd);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      direct(1'b0, 1'b0, "R1");
    end
    rst_n = 1;
    repeat (3) step(0, 0, 0, "R1");

    // R2 / R3: single-phase accumulation up to the top bit
    repeat (TOPV - 1) step(1, 0, 0, "R2");
    step(1, 0, 0, "R3");            // 16th event raises ss_discharge
    step(0, 0, 0, "R6");            // first episode counted

    // R4: both phases push past the maximum, no wrap
    repeat (20) step(1, 1, 0, "R4");

    // R5: periodic clear releases the discharge request
    repeat (PER) step(0, 0, 0, "R5");
    direct(1'b0, 1'b0, "R5");

    // R5: events on the clearing edge are dropped
    while (m_tmr != PER - 1) step(0, 0, 0, "R5");
    step(1, 1, 0, "R5");
    repeat (TOPV - 1) step(0, 1, 0, "R5");
    direct(1'b0, 1'b0, "R5");
    step(0, 1, 0, "R3");
    step(0, 0, 0, "R6");            // second episode

    // R7: third episode latches shutdown
    repeat (PER) step(0, 0, 0, "R6");
    while (m_tmr > PER - 12) step(0, 0, 0, "R6");
    repeat (TOPV / 2) step(1, 1, 0, "R2");
    step(0, 0, 0, "R7");
    direct(1'b1, 1'b1, "R7");
    repeat (2 * PER) step(0, 0, 0, "R7");
    direct(1'b1, 1'b1, "R7");

    // R8: manual clear wins over events in the same cycle
    step(1, 1, 1, "R8");
    direct(1'b0, 1'b0, "R8");
    repeat (TOPV - 1) step(1, 0, 0, "R8");
    direct(1'b0, 1'b0, "R8");
    step(1, 0, 0, "R8");
    repeat (PER) step(0, 0, 0, "R8");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule